// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block holds the request and in-service state for a linked pair of eight-line interrupt controllers, 16 request lines in all. A primary controller owns lines 0 to 7. A secondary controller owns lines 8 to 15 and hangs off primary line 2. A raise strobe carries a line number and latches a request bit. Each controller has its own mask input. The block reports whether any unmasked request exists, which line wins, and the 8-bit vector for that line.

An acknowledge moves the winning line from the request set to the in-service set. In automatic end-of-interrupt mode the acknowledge only drops the request. End-of-interrupt commands arrive on a small command port and clear in-service bits, either by explicit level or by taking the highest-priority set bit.

Mask, vector base and mode settings come from configuration inputs that are programmed elsewhere. The request and in-service sets are brought out for observation.

Top module: `irq_pair_resolver`

## Requirements
- R1: A raise strobe (`raise_valid`=1) with `raise_num` 0–7 other than 2 sets `irr_lo` bit `raise_num` at the next clock. A number 8–15 sets `irr_hi` bit (`raise_num`−8). A bit that is already set stays set.
- R2: A raise of number 2 is redirected to line 9 and sets `irr_hi` bit 1. Bit 2 of `irr_lo` is never set.
- R3: A raise strobe with `raise_num` of 16 or more changes no request bit. It drives `raise_err` high for exactly the one cycle after the strobe.
- R4: `pending` is high exactly when some request bit is set whose mask bit is 0. A mask bit of 1 hides the line and does not remove its request.
- R5: `win_num` is the lowest-numbered unmasked requesting line across 0–15. Primary lines rank ahead of secondary lines.
- R6: While `pending` is high, `win_vec` is {`base_lo`, `win_num`[2:0]} for a winner in 0–7 and {`base_hi`, `win_num`[2:0]} for a winner in 8–15.
- R7: While `pending` is low, `win_num` and `win_vec` are 0.
- R8: `ack` while `pending` is high does three things at the next clock. It clears the winner's request bit. When `auto_eoi`=0 it sets the winner's in-service bit. For a secondary winner it also sets `isr_lo` bit 2. `ack` while `pending` is low changes nothing.
- R9: With `auto_eoi`=1, an acknowledge clears the winner's request bit and sets no in-service bit.
- R10: A command (`cmd_valid`=1) whose `cmd_code` bits 4:3 are 00 and bit 5 is 1 clears one in-service bit of the controller chosen by `cmd_hi` (0 primary, 1 secondary). With bit 6 = 1 it clears the bit numbered by `cmd_code`[2:0]. With bit 6 = 0 it clears the lowest-numbered set bit.
- R11: A command with bit 5 = 0, or with bits 4:3 other than 00, leaves both in-service sets unchanged.
- R12: When a raise and an acknowledge fall in the same cycle, the winner is cleared and the raised bit is set, so raising the winner itself keeps it set. When an acknowledge and a command fall in the same cycle, the command's clear uses the old in-service set and the acknowledge's set takes precedence.
- R13: After reset, all request and in-service bits, `pending`, `win_num`, `win_vec` and `raise_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_valid | input | 1 | Raise strobe |
| raise_num | input | 5 | Line number for the raise |
| mask_lo | input | 8 | Primary mask, 1 hides a line |
| mask_hi | input | 8 | Secondary mask, 1 hides a line |
| base_lo | input | 5 | Primary vector base |
| base_hi | input | 5 | Secondary vector base |
| auto_eoi | input | 1 | Automatic end-of-interrupt mode |
| ack | input | 1 | Acknowledge of the current winner |
| cmd_valid | input | 1 | Command strobe |
| cmd_hi | input | 1 | Command target, 1 selects secondary |
| cmd_code | input | 7 | Command byte, level in bits 2:0 |
| raise_err | output | 1 | Out-of-range raise seen last cycle |
| pending | output | 1 | Unmasked request present |
| win_num | output | 4 | Winning line number |
| win_vec | output | 8 | Vector of the winning line |
| irr_lo | output | 8 | Primary request set |
| irr_hi | output | 8 | Secondary request set |
| isr_lo | output | 8 | Primary in-service set |
| isr_hi | output | 8 | Secondary in-service set |

## Verification
Two updates can land on the same register in one cycle. A raise and an acknowledge can both change the request set. An acknowledge and an end-of-interrupt command can both change the in-service set. The bench provokes both collisions with single-cycle strobes driven together. These include a raise of the very line being acknowledged, and a specific end-of-interrupt aimed at the bit the acknowledge is setting. It judges each one by the bit pattern it computes from the set-over-clear rule.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;

    localparam int LINES        = 8;
    localparam int NUM_CTRL     = 2;
    localparam int LINE_W       = $clog2(LINES);
    localparam int TOTAL        = LINES * NUM_CTRL;
    localparam int IRQ_W        = $clog2(TOTAL);
    localparam int RAISE_W      = IRQ_W + 1;
    localparam int BASE_W       = 5;
    localparam int VEC_W        = BASE_W + LINE_W;
    localparam int CMD_W        = 7;

    // cascade wiring: primary line that carries the secondary, and the
    // line a raise of that number is redirected to
    localparam int CASCADE_LINE = 2;
    localparam int REDIRECT_IRQ = 9;

    // command byte fields decoded by the end-of-interrupt logic
    localparam int CMD_TYPE_LO  = 3;
    localparam int CMD_EOI_BIT  = 5;
    localparam int CMD_SPEC_BIT = 6;

    typedef logic [LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t [NUM_CTRL-1:0] req;
        line_vec_t [NUM_CTRL-1:0] svc;
        logic                     err;
    } res_state_t;

endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // lowest set index wins; zero when nothing is set
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_raise_decode.sv
module irq_raise_decode
    import irq_pair_pkg::*;
#(
    parameter int CASC  = CASCADE_LINE,
    parameter int REDIR = REDIRECT_IRQ
) (
    input  logic               valid,
    input  logic [RAISE_W-1:0] num,
    output logic [TOTAL-1:0]   set_vec,
    output logic               bad
);

    logic             in_range;
    logic [IRQ_W-1:0] eff;

    always_comb begin
        in_range = (num < RAISE_W'(TOTAL));
        bad      = valid && !in_range;
        eff      = (num == RAISE_W'(CASC)) ? IRQ_W'(REDIR) : num[IRQ_W-1:0];
        set_vec  = '0;
        for (int i = 0; i < TOTAL; i++) begin
            if (valid && in_range && (eff == IRQ_W'(i))) begin
                set_vec[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_eoi_decode.sv
module irq_eoi_decode
    import irq_pair_pkg::*;
(
    input  logic             hit,
    input  logic [CMD_W-1:0] cmd,
    input  line_vec_t        svc,
    output line_vec_t        clr
);

    logic              any_svc;
    logic [LINE_W-1:0] low_idx;
    logic              is_eoi;

    irq_prio_scan #(
        .W  (LINES),
        .IW (LINE_W)
    ) i_low (
        .vec   (svc),
        .found (any_svc),
        .idx   (low_idx)
    );

    always_comb begin
        is_eoi = hit
              && (cmd[CMD_TYPE_LO+1:CMD_TYPE_LO] == 2'b00)
              && cmd[CMD_EOI_BIT];
        clr = '0;
        if (is_eoi) begin
            if (cmd[CMD_SPEC_BIT]) begin
                clr[cmd[LINE_W-1:0]] = 1'b1;
            end else if (any_svc) begin
                clr[low_idx] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_pair_resolver.sv
module irq_pair_resolver
    import irq_pair_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raise_valid,
    input  logic [RAISE_W-1:0] raise_num,
    input  logic [LINES-1:0]   mask_lo,
    input  logic [LINES-1:0]   mask_hi,
    input  logic [BASE_W-1:0]  base_lo,
    input  logic [BASE_W-1:0]  base_hi,
    input  logic               auto_eoi,
    input  logic               ack,
    input  logic               cmd_valid,
    input  logic               cmd_hi,
    input  logic [CMD_W-1:0]   cmd_code,
    output logic               raise_err,
    output logic               pending,
    output logic [IRQ_W-1:0]   win_num,
    output logic [VEC_W-1:0]   win_vec,
    output logic [LINES-1:0]   irr_lo,
    output logic [LINES-1:0]   irr_hi,
    output logic [LINES-1:0]   isr_lo,
    output logic [LINES-1:0]   isr_hi
);

    localparam int CTRL_W = IRQ_W - LINE_W;

    res_state_t st_d, st_q;

    line_vec_t [NUM_CTRL-1:0]              mask_a;
    logic      [NUM_CTRL-1:0][BASE_W-1:0] base_a;
    line_vec_t [NUM_CTRL-1:0]              eoi_clr;
    logic      [TOTAL-1:0]                 live;
    logic      [TOTAL-1:0]                 raise_set;
    logic                                  raise_bad;
    logic                                  any_live;
    logic      [IRQ_W-1:0]                 win_idx;
    logic      [CTRL_W-1:0]                win_ctrl;
    logic      [LINE_W-1:0]                win_line;
    logic                                  take;
    logic      [TOTAL-1:0]                 take_vec;
    logic      [TOTAL-1:0]                 svc_set;

    assign mask_a   = {mask_hi, mask_lo};
    assign base_a   = {base_hi, base_lo};
    assign live     = st_q.req & ~mask_a;
    assign win_ctrl = win_idx[IRQ_W-1:LINE_W];
    assign win_line = win_idx[LINE_W-1:0];

    irq_raise_decode i_raise (
        .valid   (raise_valid),
        .num     (raise_num),
        .set_vec (raise_set),
        .bad     (raise_bad)
    );

    irq_prio_scan #(
        .W  (TOTAL),
        .IW (IRQ_W)
    ) i_win (
        .vec   (live),
        .found (any_live),
        .idx   (win_idx)
    );

    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_eoi
        irq_eoi_decode i_eoi (
            .hit (cmd_valid && (cmd_hi == 1'(c))),
            .cmd (cmd_code),
            .svc (st_q.svc[c]),
            .clr (eoi_clr[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        take     = ack && any_live;
        take_vec = take ? (TOTAL'(1) << win_idx) : '0;
        svc_set  = (take && !auto_eoi) ? take_vec : '0;
        if (take && !auto_eoi && (win_ctrl != '0)) begin
            svc_set[CASCADE_LINE] = 1'b1;
        end
        st_d.req = (st_q.req & ~take_vec) | raise_set;
        st_d.svc = (st_q.svc & ~eoi_clr) | svc_set;
        st_d.err = raise_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending   = any_live;
    assign win_num   = win_idx;
    assign win_vec   = any_live ? {base_a[win_ctrl], win_line} : '0;
    assign raise_err = st_q.err;
    assign irr_lo    = st_q.req[0];
    assign irr_hi    = st_q.req[1];
    assign isr_lo    = st_q.svc[0];
    assign isr_hi    = st_q.svc[1];

endmodule

// File: rtl/irq_pair_resolver_chk.sv
module irq_pair_resolver_chk
    import irq_pair_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               raise_valid,
    input logic [RAISE_W-1:0] raise_num,
    input logic [LINES-1:0]   mask_lo,
    input logic [LINES-1:0]   mask_hi,
    input logic               auto_eoi,
    input logic               ack,
    input logic               cmd_valid,
    input logic               raise_err,
    input logic               pending,
    input logic [IRQ_W-1:0]   win_num,
    input logic [VEC_W-1:0]   win_vec,
    input logic [LINES-1:0]   irr_lo,
    input logic [LINES-1:0]   irr_hi,
    input logic [LINES-1:0]   isr_lo,
    input logic [LINES-1:0]   isr_hi
);

    logic [TOTAL-1:0] irr_all;
    logic [TOTAL-1:0] live_all;

    assign irr_all  = {irr_hi, irr_lo};
    assign live_all = irr_all & ~{mask_hi, mask_lo};

    assert_cascade_line_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irr_lo[CASCADE_LINE] == 1'b0);

    assert_bad_raise_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && (raise_num >= RAISE_W'(TOTAL))) |=> raise_err);

    assert_bad_raise_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && (raise_num >= RAISE_W'(TOTAL)) && !ack)
        |=> (irr_all == $past(irr_all)));

    assert_pending_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pending == (live_all != '0));

    assert_winner_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (live_all[win_num]
                     && ((live_all & ((TOTAL'(1) << win_num) - TOTAL'(1))) == '0)));

    assert_idle_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> ((win_num == '0) && (win_vec == '0)));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pending && !raise_valid) |=> !irr_all[$past(win_num)]);

    assert_auto_no_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi && !cmd_valid)
        |=> ((isr_lo == $past(isr_lo)) && (isr_hi == $past(isr_hi))));

endmodule

bind irq_pair_resolver irq_pair_resolver_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_valid (raise_valid),
    .raise_num   (raise_num),
    .mask_lo     (mask_lo),
    .mask_hi     (mask_hi),
    .auto_eoi    (auto_eoi),
    .ack         (ack),
    .cmd_valid   (cmd_valid),
    .raise_err   (raise_err),
    .pending     (pending),
    .win_num     (win_num),
    .win_vec     (win_vec),
    .irr_lo      (irr_lo),
    .irr_hi      (irr_hi),
    .isr_lo      (isr_lo),
    .isr_hi      (isr_hi)
);

// File: tb/test_irq_pair_resolver.sv
module test_irq_pair_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raise_valid = 1'b0;
    logic [4:0] raise_num = '0;
    logic [7:0] mask_lo = '0;
    logic [7:0] mask_hi = '0;
    logic [4:0] base_lo = 5'h09;
    logic [4:0] base_hi = 5'h1C;
    logic       auto_eoi = 1'b0;
    logic       ack = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_hi = 1'b0;
    logic [6:0] cmd_code = '0;
    logic       raise_err;
    logic       pending;
    logic [3:0] win_num;
    logic [7:0] win_vec;
    logic [7:0] irr_lo, irr_hi, isr_lo, isr_hi;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_pair_resolver i_irq_pair_resolver (
        .clk (clk), .rst_n (rst_n), .raise_valid (raise_valid), .raise_num (raise_num),
        .mask_lo (mask_lo), .mask_hi (mask_hi), .base_lo (base_lo), .base_hi (base_hi),
        .auto_eoi (auto_eoi), .ack (ack), .cmd_valid (cmd_valid), .cmd_hi (cmd_hi),
        .cmd_code (cmd_code), .raise_err (raise_err), .pending (pending),
        .win_num (win_num), .win_vec (win_vec), .irr_lo (irr_lo), .irr_hi (irr_hi),
        .isr_lo (isr_lo), .isr_hi (isr_hi)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock of strobes, driven at a falling edge, results visible at the next
    task automatic step(input logic rv, input logic [4:0] rn, input logic ak,
                        input logic cv, input logic ch, input logic [6:0] cc);
        raise_valid = rv; raise_num = rn; ack = ak;
        cmd_valid = cv; cmd_hi = ch; cmd_code = cc;
        @(negedge clk);
        raise_valid = 1'b0; ack = 1'b0; cmd_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mask_lo = '0; mask_hi = '0; auto_eoi = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int eff_line(input int n);
        return (n == 2) ? 9 : n;
    endfunction

    function automatic logic [7:0] exp_vec(input int e);
        return (e < 8) ? {base_lo, 3'(e)} : {base_hi, 3'(e)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] m_irr, m_isr;
        do_reset();
        // R13 reset state
        chk("R13 irr", {irr_hi, irr_lo}, 16'h0);
        chk("R13 isr", {isr_hi, isr_lo}, 16'h0);
        chk("R13 pend/err", {14'h0, pending, raise_err}, 16'h0);
        chk("R13 win", {4'h0, win_num, win_vec}, 16'h0);

        // single-line sweep: R1 R2 R4 R5 R6 R8 R7 R10
        for (int n = 0; n < 16; n++) begin
            int e;
            logic [15:0] ex_isr;
            e = eff_line(n);
            do_reset();
            step(1'b1, 5'(n), 1'b0, 1'b0, 1'b0, 7'h0);
            chk((n == 2) ? "R2 redirect" : "R1 raise", {irr_hi, irr_lo}, 16'(1) << e);
            chk("R4 pending", {15'h0, pending}, 16'h1);
            chk("R5 winner", {12'h0, win_num}, 16'(e));
            chk("R6 vector", {8'h0, win_vec}, {8'h0, exp_vec(e)});
            step(1'b0, 5'h0, 1'b1, 1'b0, 1'b0, 7'h0);
            ex_isr = 16'(1) << e;
            if (e >= 8) ex_isr[2] = 1'b1;
            chk("R8 irr cleared", {irr_hi, irr_lo}, 16'h0);
            chk("R8 isr set", {isr_hi, isr_lo}, ex_isr);
            chk("R7 idle", {3'h0, pending, win_num, win_vec}, 16'h0);
            step(1'b0, 5'h0, 1'b0, 1'b1, 1'b1, 7'h20);
            step(1'b0, 5'h0, 1'b0, 1'b1, 1'b0, 7'h20);
            chk("R10 nonspecific clear", {isr_hi, isr_lo}, 16'h0);
        end

        // out-of-range raises: R3
        do_reset();
        step(1'b1, 5'd5, 1'b0, 1'b0, 1'b0, 7'h0);
        for (int n = 16; n < 32; n++) begin
            step(1'b1, 5'(n), 1'b0, 1'b0, 1'b0, 7'h0);
            chk("R3 err high", {15'h0, raise_err}, 16'h1);
            chk("R3 irr unchanged", {irr_hi, irr_lo}, 16'h0020);
            step(1'b0, 5'h0, 1'b0, 1'b0, 1'b0, 7'h0);
            chk("R3 err one cycle", {15'h0, raise_err}, 16'h0);
        end

        // all lines raised, mask sweep: R1 R2 R4 R5 R7
        do_reset();
        for (int n = 0; n < 16; n++) step(1'b1, 5'(n), 1'b0, 1'b0, 1'b0, 7'h0);
        step(1'b1, 5'd5, 1'b0, 1'b0, 1'b0, 7'h0);
        chk("R2 all raised", {irr_hi, irr_lo}, 16'hFFFB);
        for (int k = 0; k <= 16; k++) begin
            logic [15:0] mk;
            int w;
            logic p;
            mk = (k == 16) ? 16'hFFFF : ((16'(1) << k) - 16'(1));
            mask_lo = mk[7:0]; mask_hi = mk[15:8];
            @(negedge clk);
            w = 0; p = 1'b0;
            for (int j = 15; j >= 0; j--) begin
                if (j != 2 && j >= k) begin w = j; p = 1'b1; end
            end
            chk("R4 masked pending", {15'h0, pending}, {15'h0, p});
            chk("R5 masked winner", {12'h0, win_num}, 16'(w));
            if (!p) chk("R7 all masked", {8'h0, win_vec}, 16'h0);
        end
        chk("R4 mask keeps requests", {irr_hi, irr_lo}, 16'hFFFB);
        mask_lo = '0; mask_hi = '0;
        @(negedge clk);

        // acknowledge order: R5 R8
        m_irr = 16'hFFFB; m_isr = 16'h0;
        for (int i = 0; i < 15; i++) begin
            int w;
            w = 0;
            for (int j = 15; j >= 0; j--) if (m_irr[j]) w = j;
            chk("R5 ack order", {12'h0, win_num}, 16'(w));
            step(1'b0, 5'h0, 1'b1, 1'b0, 1'b0, 7'h0);
            m_irr[w] = 1'b0;
            m_isr[w] = 1'b1;
            if (w >= 8) m_isr[2] = 1'b1;
            chk("R8 ack isr", {isr_hi, isr_lo}, m_isr);
        end
        chk("R8 all served", {irr_hi, irr_lo}, 16'h0);
        step(1'b0, 5'h0, 1'b0, 1'b1, 1'b1, 7'h65);
        chk("R10 specific hi", {8'h0, isr_hi}, 16'h00DF);
        step(1'b0, 5'h0, 1'b0, 1'b1, 1'b1, 7'h20);
        chk("R10 nonspecific hi", {8'h0, isr_hi}, 16'h00DE);
        step(1'b0, 5'h0, 1'b0, 1'b1, 1'b0, 7'h63);
        chk("R10 specific lo", {8'h0, isr_lo}, 16'h00F7);
        step(1'b0, 5'h0, 1'b0, 1'b1, 1'b0, 7'h28);
        chk("R11 wrong type", {isr_hi, isr_lo}, 16'hDEF7);
        step(1'b0, 5'h0, 1'b0, 1'b1, 1'b0, 7'h05);
        chk("R11 no eoi bit", {isr_hi, isr_lo}, 16'hDEF7);
        step(1'b0, 5'h0, 1'b0, 1'b1, 1'b1, 7'h43);
        chk("R11 specific without eoi", {isr_hi, isr_lo}, 16'hDEF7);

        // automatic end of interrupt: R9
        do_reset();
        auto_eoi = 1'b1;
        step(1'b1, 5'd4, 1'b0, 1'b0, 1'b0, 7'h0);
        step(1'b1, 5'd12, 1'b0, 1'b0, 1'b0, 7'h0);
        step(1'b0, 5'h0, 1'b1, 1'b0, 1'b0, 7'h0);
        chk("R9 irr after first", {irr_hi, irr_lo}, 16'h1000);
        chk("R9 isr empty", {isr_hi, isr_lo}, 16'h0);
        step(1'b0, 5'h0, 1'b1, 1'b0, 1'b0, 7'h0);
        chk("R9 irr after second", {irr_hi, irr_lo}, 16'h0);
        chk("R9 isr still empty", {isr_hi, isr_lo}, 16'h0);
        auto_eoi = 1'b0;

        // same-cycle collisions: R12, idle ack: R8
        do_reset();
        step(1'b1, 5'd1, 1'b0, 1'b0, 1'b0, 7'h0);
        step(1'b1, 5'd3, 1'b1, 1'b0, 1'b0, 7'h0);
        chk("R12 raise+ack irr", {irr_hi, irr_lo}, 16'h0008);
        chk("R12 raise+ack isr", {isr_hi, isr_lo}, 16'h0002);
        step(1'b1, 5'd3, 1'b1, 1'b0, 1'b0, 7'h0);
        chk("R12 raise of winner", {irr_hi, irr_lo}, 16'h0008);
        chk("R12 raise of winner isr", {isr_hi, isr_lo}, 16'h000A);
        step(1'b1, 5'd4, 1'b0, 1'b0, 1'b0, 7'h0);
        step(1'b0, 5'h0, 1'b1, 1'b1, 1'b0, 7'h63);
        chk("R12 ack+specific same bit", {isr_hi, isr_lo}, 16'h000A);
        chk("R12 ack+specific irr", {irr_hi, irr_lo}, 16'h0010);
        step(1'b0, 5'h0, 1'b1, 1'b1, 1'b0, 7'h20);
        chk("R12 ack+nonspecific", {isr_hi, isr_lo}, 16'h0018);
        step(1'b0, 5'h0, 1'b1, 1'b0, 1'b0, 7'h0);
        chk("R8 idle ack isr", {isr_hi, isr_lo}, 16'h0018);
        chk("R8 idle ack irr", {irr_hi, irr_lo}, 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule